// File: doc/BRIEF.md
# Set-Limited Directory Cache with Recall

This block tracks which private caches hold each on-chip block, using a sharer bit vector per directory entry. The directory is inclusive: every block held by any private cache has an entry. A lookup that misses therefore proves that no cache holds the block. The directory has fewer ways per set than the total number of private-cache ways that could map to one set. Because of this, a request can arrive that needs a new entry in a set where every way is already in use.

In that case the block does not drop an entry silently. It picks a resident victim from a per-set round-robin pointer and sends one invalidation to every cache named in the victim's sharer vector. It then waits until each of those caches has acknowledged. Only then does it free the victim way and serve the stalled request in that way. While the recall runs, new requests are held off through the ready signal, but acknowledgments are still taken. Caches are expected to report shared-copy evictions with an explicit release request, so that entries empty out and fewer recalls are needed.

Each served request produces a one-cycle response carrying the hit flag and the sharer vector as it stood before the request. The requester's own flow uses that vector to forward or invalidate copies.

Top module: `dir_recall_cache`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1 and inv_valid and rsp_valid are 0. The directory starts empty.
- R2: A request that misses and finds a free way in its set is served without a recall. The set index is the low address bits and the tag is the remaining high bits. rsp_valid rises in the cycle after acceptance, with rsp_hit 0, rsp_sharers all zero, and rsp_addr and rsp_cid echoing the request. A read-share request (op 0) or an exclusive request (op 1) then leaves the requester as the only sharer.
- R3: A read-share request (op 0) that hits adds the requester's bit to the entry. Bit i of a sharer vector stands for cache i. The response has rsp_hit 1 and the vector as it was before the request.
- R4: An exclusive request (op 1) that hits leaves the requester as the only sharer. The response has rsp_hit 1 and the prior vector.
- R5: A release (op 2) clears the requester's bit. When the vector becomes empty, the way is freed, so a later allocation in that set needs no recall. A release for an absent block changes nothing and answers with rsp_hit 0 and an empty vector.
- R6: An allocating request (op 0 or 1) that misses in a full set starts a recall. The victim is the way named by that set's round-robin pointer. The pointer starts at way 0 and moves on by one, wrapping, after each recall. Invalidations go out one per cycle, in ascending cache ID order, to every sharer of the victim. The first is in the cycle after acceptance, and inv_addr carries the victim's block address.
- R7: req_ready is 0 from the cycle after the recall-triggering request is accepted up to the cycle in which its response appears.
- R8: A recall waits for one acknowledgment from each cache in the victim's vector. An acknowledgment from a cache outside that vector, or one that arrives when no recall is running, has no effect.
- R9: The stalled request is answered in the second cycle after the cycle in which its last owed acknowledgment is presented. The answer has rsp_hit 0 and an empty vector. The new entry holds only the requester, and the recalled block misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (0 during a recall) |
| req_op | input | 2 | 0 read-share, 1 exclusive, 2 release |
| req_addr | input | TAG_W+SET_W | Block address, set index in the low bits |
| req_src | input | CID_W | Requesting cache ID |
| inv_valid | output | 1 | Invalidation message this cycle |
| inv_addr | output | TAG_W+SET_W | Block being recalled |
| inv_cid | output | CID_W | Cache the invalidation is addressed to |
| ack_valid | input | 1 | Invalidation acknowledgment present |
| ack_cid | input | CID_W | Cache sending the acknowledgment |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | TAG_W+SET_W | Address of the served request |
| rsp_cid | output | CID_W | Requester of the served request |
| rsp_hit | output | 1 | Entry was present before the request |
| rsp_sharers | output | NUM_CACHES | Sharer vector before the request |

## Verification
The main function is driven with hits that grow, collapse and shrink a sharer vector, with releases that empty an entry so that a following allocation must reuse the freed way without a recall, and with allocations into full sets. Those allocations recall victims holding one sharer and victims holding two, and are triggered by both read-share and exclusive requests. Three recalls in a row in one set show whether the round-robin pointer advances and wraps. The recalled block is then requested again to show that it was really dropped. Acknowledgments from caches outside the victim's vector, and acknowledgments sent while idle, separate a design that counts only owed acknowledgments from one that counts any acknowledgment it sees.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

  typedef enum logic [1:0] {
    OP_GETS = 2'd0,
    OP_GETM = 2'd1,
    OP_PUTS = 2'd2
  } dir_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_RECALL = 1'b1
  } dir_state_e;

  localparam int unsigned VEC_MAX = 32;

  // Number of set bits in a vector of up to VEC_MAX caches.
  function automatic int unsigned ones_in(input logic [VEC_MAX-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < VEC_MAX; i++) n += 32'(v[i]);
    return n;
  endfunction

  // Index of the lowest set bit (0 when the vector is empty).
  function automatic int unsigned first_one(input logic [VEC_MAX-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = VEC_MAX - 1; i >= 0; i--) if (v[i]) idx = 32'(i);
    return idx;
  endfunction

  // Vector with its lowest set bit cleared.
  function automatic logic [VEC_MAX-1:0] drop_first(input logic [VEC_MAX-1:0] v);
    return v & (v - VEC_MAX'(1));
  endfunction

endpackage

// File: rtl/dirc_lookup.sv
module dirc_lookup #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            ent_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = ent_valid[w] && (ent_tag[w] == key);
  end

  assign hit      = |match;
  assign has_free = |(~ent_valid);

  // Lowest matching way and lowest empty way.
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = int'(WAYS) - 1; w >= 0; w--) begin
      if (match[w])      hit_way  = WAY_W'(w);
      if (!ent_valid[w]) free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/dirc_store.sv
module dirc_store #(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned NC    = 4,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0][NC-1:0]    rd_shr,
  output logic [WAY_W-1:0]           rd_rr,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic                       wr_valid,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [NC-1:0]              wr_shr,
  input  logic                       rr_step
);

  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][NC-1:0]    shr_q [SETS];
  logic [WAY_W-1:0]           rr_q  [SETS];

  function automatic logic [WAY_W-1:0] rr_next(input logic [WAY_W-1:0] p);
    return (p == WAY_W'(WAYS - 1)) ? '0 : p + WAY_W'(1);
  endfunction

  assign rd_valid = vld_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_shr   = shr_q[rd_set];
  assign rd_rr    = rr_q[rd_set];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en && (wr_set == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= '0;
        tag_q[s] <= '0;
        shr_q[s] <= '0;
        rr_q[s]  <= '0;
      end else begin
        if (sel) begin
          vld_q[s][wr_way] <= wr_valid;
          tag_q[s][wr_way] <= wr_tag;
          shr_q[s][wr_way] <= wr_shr;
          if (rr_step) rr_q[s] <= rr_next(rr_q[s]);
        end
      end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      // R5
      live_entry_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[s][w] |-> (shr_q[s][w] != '0));
    end
  end

endmodule

// File: rtl/dirc_recall.sv
module dirc_recall
  import dirc_pkg::*;
#(
  parameter int unsigned NC = 4,
  localparam int unsigned CID_W = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned CNT_W = $clog2(NC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NC-1:0]    start_vec,
  input  logic             ack_valid,
  input  logic [CID_W-1:0] ack_cid,
  output logic             busy,
  output logic             inv_valid,
  output logic [CID_W-1:0] inv_cid,
  output logic             done
);

  logic             busy_q;
  logic [NC-1:0]    pend_q;   // invalidations still to send
  logic [NC-1:0]    wait_q;   // caches whose acknowledgment is owed
  logic [CNT_W-1:0] cnt_q;    // number of owed acknowledgments
  logic [NC-1:0]    ack_bit;
  logic             ack_take;

  assign ack_bit   = NC'(1) << ack_cid;
  assign ack_take  = busy_q && ack_valid && |(wait_q & ack_bit);
  assign busy      = busy_q;
  assign inv_valid = busy_q && |pend_q;
  assign inv_cid   = CID_W'(first_one(VEC_MAX'(pend_q)));
  assign done      = busy_q && (pend_q == '0) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pend_q <= start_vec;
      wait_q <= start_vec;
      cnt_q  <= CNT_W'(ones_in(VEC_MAX'(start_vec)));
    end else if (busy_q) begin
      if (inv_valid) pend_q <= NC'(drop_first(VEC_MAX'(pend_q)));
      if (ack_take) begin
        wait_q <= wait_q & ~ack_bit;
        cnt_q  <= cnt_q - CNT_W'(1);
      end
      if (done) busy_q <= 1'b0;
    end
  end

  // R8
  owed_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) == $countones(wait_q)));

  // R9
  drained_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(wait_q) == '0));

endmodule

// File: rtl/dir_recall_cache.sv
module dir_recall_cache
  import dirc_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned DIR_SETS   = 4,
  parameter int unsigned DIR_WAYS   = 2,
  parameter int unsigned TAG_W      = 4,
  localparam int unsigned SET_W  = (DIR_SETS > 1) ? $clog2(DIR_SETS) : 1,
  localparam int unsigned WAY_W  = (DIR_WAYS > 1) ? $clog2(DIR_WAYS) : 1,
  localparam int unsigned CID_W  = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  localparam int unsigned ADDR_W = TAG_W + SET_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [CID_W-1:0]      req_src,
  output logic                  inv_valid,
  output logic [ADDR_W-1:0]     inv_addr,
  output logic [CID_W-1:0]      inv_cid,
  input  logic                  ack_valid,
  input  logic [CID_W-1:0]      ack_cid,
  output logic                  rsp_valid,
  output logic [ADDR_W-1:0]     rsp_addr,
  output logic [CID_W-1:0]      rsp_cid,
  output logic                  rsp_hit,
  output logic [NUM_CACHES-1:0] rsp_sharers
);

  localparam int unsigned NC = NUM_CACHES;

  // Sharer vector after a request that found the entry (or allocated it).
  function automatic logic [NC-1:0] next_sharers(input dir_op_e op,
                                                 input logic [NC-1:0] prior,
                                                 input logic [NC-1:0] me);
    case (op)
      OP_GETS: return prior | me;
      OP_GETM: return me;
      OP_PUTS: return prior & ~me;
      default: return prior;
    endcase
  endfunction

  dir_state_e        state_q;
  logic [ADDR_W-1:0] pnd_addr_q;
  logic [CID_W-1:0]  pnd_src_q;
  logic [WAY_W-1:0]  vic_way_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;

  logic [DIR_WAYS-1:0]            rd_valid;
  logic [DIR_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [DIR_WAYS-1:0][NC-1:0]    rd_shr;
  logic [WAY_W-1:0]               rd_rr;

  logic             lk_hit, lk_has_free;
  logic [WAY_W-1:0] lk_hit_way, lk_free_way;

  logic             wr_en, wr_valid, rr_step;
  logic [WAY_W-1:0] wr_way;
  logic [NC-1:0]    wr_shr;

  logic             rc_busy, rc_inv_valid, rc_done;
  logic [CID_W-1:0] rc_inv_cid;

  // Named internal events
  dir_op_e       op_in;
  logic          req_fire;
  logic [NC-1:0] prior_shr;
  logic [NC-1:0] src_bit;
  logic          want_alloc;
  logic          recall_start;
  logic          serve_now;
  logic          recall_done;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign op_in     = dir_op_e'(req_op);

  assign cur_addr = (state_q == ST_IDLE) ? req_addr : pnd_addr_q;
  assign cur_set  = cur_addr[SET_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:SET_W];

  dirc_store #(
    .SETS (DIR_SETS),
    .WAYS (DIR_WAYS),
    .TAG_W(TAG_W),
    .NC   (NC)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (cur_set),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_shr  (rd_shr),
    .rd_rr   (rd_rr),
    .wr_en   (wr_en),
    .wr_set  (cur_set),
    .wr_way  (wr_way),
    .wr_valid(wr_valid),
    .wr_tag  (cur_tag),
    .wr_shr  (wr_shr),
    .rr_step (rr_step)
  );

  dirc_lookup #(
    .WAYS (DIR_WAYS),
    .TAG_W(TAG_W)
  ) u_lookup (
    .ent_valid(rd_valid),
    .ent_tag  (rd_tag),
    .key      (cur_tag),
    .hit      (lk_hit),
    .hit_way  (lk_hit_way),
    .has_free (lk_has_free),
    .free_way (lk_free_way)
  );

  assign prior_shr    = lk_hit ? rd_shr[lk_hit_way] : '0;
  assign src_bit      = NC'(1) << req_src;
  assign want_alloc   = !lk_hit && (op_in != OP_PUTS);
  assign recall_start = req_fire && want_alloc && !lk_has_free;
  assign serve_now    = req_fire && !recall_start;

  dirc_recall #(
    .NC(NC)
  ) u_recall (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (recall_start),
    .start_vec(rd_shr[rd_rr]),
    .ack_valid(ack_valid),
    .ack_cid  (ack_cid),
    .busy     (rc_busy),
    .inv_valid(rc_inv_valid),
    .inv_cid  (rc_inv_cid),
    .done     (rc_done)
  );

  assign recall_done = rc_done && (state_q == ST_RECALL);

  // Directory write port: direct service or replay into the freed victim way.
  always_comb begin
    wr_en    = 1'b0;
    wr_valid = 1'b0;
    wr_way   = '0;
    wr_shr   = '0;
    rr_step  = 1'b0;
    if (serve_now && (lk_hit || want_alloc)) begin
      wr_en    = 1'b1;
      wr_way   = lk_hit ? lk_hit_way : lk_free_way;
      wr_shr   = next_sharers(op_in, prior_shr, src_bit);
      wr_valid = |wr_shr;
    end else if (recall_done) begin
      wr_en    = 1'b1;
      wr_way   = vic_way_q;
      wr_shr   = NC'(1) << pnd_src_q;
      wr_valid = 1'b1;
      rr_step  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pnd_addr_q <= '0;
      pnd_src_q  <= '0;
      vic_way_q  <= '0;
    end else if (recall_start) begin
      state_q    <= ST_RECALL;
      pnd_addr_q <= req_addr;
      pnd_src_q  <= req_src;
      vic_way_q  <= rd_rr;
    end else if (recall_done) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_cid     <= '0;
      rsp_hit     <= 1'b0;
      rsp_sharers <= '0;
    end else if (serve_now) begin
      rsp_valid   <= 1'b1;
      rsp_addr    <= req_addr;
      rsp_cid     <= req_src;
      rsp_hit     <= lk_hit;
      rsp_sharers <= prior_shr;
    end else if (recall_done) begin
      rsp_valid   <= 1'b1;
      rsp_addr    <= pnd_addr_q;
      rsp_cid     <= pnd_src_q;
      rsp_hit     <= 1'b0;
      rsp_sharers <= '0;
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  assign inv_valid = rc_inv_valid;
  assign inv_cid   = rc_inv_cid;
  assign inv_addr  = {rd_tag[vic_way_q], pnd_addr_q[SET_W-1:0]};

  // R7
  recall_holds_off_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_busy |-> !req_ready);

  // R6
  inv_targets_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> rd_shr[vic_way_q][inv_cid]);

  // R2
  miss_reports_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_sharers == '0));

  // R9
  replay_follows_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |=> (rsp_valid && !rsp_hit && req_ready));

endmodule

// File: tb/tb_dir_recall_cache.sv
module tb_dir_recall_cache;

  localparam int NC     = 4;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;
  localparam int TAG_W  = 4;
  localparam int SET_W  = 2;
  localparam int CID_W  = 2;
  localparam int ADDR_W = TAG_W + SET_W;

  logic              clk, rst_n;
  logic              req_valid, req_ready;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [CID_W-1:0]  req_src;
  logic              inv_valid;
  logic [ADDR_W-1:0] inv_addr;
  logic [CID_W-1:0]  inv_cid;
  logic              ack_valid;
  logic [CID_W-1:0]  ack_cid;
  logic              rsp_valid;
  logic [ADDR_W-1:0] rsp_addr;
  logic [CID_W-1:0]  rsp_cid;
  logic              rsp_hit;
  logic [NC-1:0]     rsp_sharers;

  dir_recall_cache #(
    .NUM_CACHES(NC),
    .DIR_SETS  (SETS),
    .DIR_WAYS  (WAYS),
    .TAG_W     (TAG_W)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_src(req_src),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_cid(inv_cid),
    .ack_valid(ack_valid), .ack_cid(ack_cid),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_cid(rsp_cid),
    .rsp_hit(rsp_hit), .rsp_sharers(rsp_sharers)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural reference state
  int m_vld [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_shr [SETS][WAYS];
  int m_rr  [SETS];

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Issue one request and follow it to its response, predicting every cycle.
  task automatic send_req(input int op, input int tag, input int set, input int src,
                          input string rq, input bit bogus);
    int addr, hw, fw, hit, old, vic, vec, nxt, way, vaddr, stranger;
    addr = (tag << SET_W) | set;
    hit = 0; hw = 0; fw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[set][w] != 0 && m_tag[set][w] == tag) begin hit = 1; hw = w; end
    for (int w = WAYS - 1; w >= 0; w--)
      if (m_vld[set][w] == 0) fw = w;
    old = hit ? m_shr[set][hw] : 0;

    chk(rq, "req_ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_op    = op[1:0];
    req_addr  = addr[ADDR_W-1:0];
    req_src   = src[CID_W-1:0];
    tick();
    req_valid = 1'b0;

    if (hit == 1 || op == 2 || fw >= 0) begin
      chk(rq, "rsp_valid", int'(rsp_valid), 1);
      chk(rq, "rsp_hit", int'(rsp_hit), hit);
      chk(rq, "rsp_sharers", int'(rsp_sharers), old);
      chk(rq, "rsp_addr", int'(rsp_addr), addr);
      chk(rq, "rsp_cid", int'(rsp_cid), src);
      chk(rq, "no invalidation without recall", int'(inv_valid), 0);
      if (op == 2) begin
        if (hit == 1) begin
          nxt = old & ~(1 << src);
          m_shr[set][hw] = nxt;
          if (nxt == 0) m_vld[set][hw] = 0;
        end
      end else begin
        way = (hit == 1) ? hw : fw;
        if (op == 0) nxt = old | (1 << src);
        else         nxt = 1 << src;
        m_vld[set][way] = 1;
        m_tag[set][way] = tag;
        m_shr[set][way] = nxt;
      end
    end else begin
      vic   = m_rr[set];
      vec   = m_shr[set][vic];
      vaddr = (m_tag[set][vic] << SET_W) | set;
      for (int c = 0; c < NC; c++) begin
        if (((vec >> c) & 1) != 0) begin
          chk("R6", "inv_valid", int'(inv_valid), 1);
          chk("R6", "inv_cid order", int'(inv_cid), c);
          chk("R6", "inv_addr victim", int'(inv_addr), vaddr);
          chk("R7", "req_ready during recall", int'(req_ready), 0);
          chk("R9", "no early response", int'(rsp_valid), 0);
          tick();
        end
      end
      chk("R6", "invalidations finished", int'(inv_valid), 0);
      if (bogus) begin
        stranger = -1;
        for (int c = NC - 1; c >= 0; c--)
          if (((vec >> c) & 1) == 0) stranger = c;
        if (stranger >= 0) begin
          ack_valid = 1'b1;
          ack_cid   = stranger[CID_W-1:0];
          tick();
          ack_valid = 1'b0;
          tick();
          chk("R8", "ack from non-sharer ignored (rsp)", int'(rsp_valid), 0);
          chk("R8", "ack from non-sharer ignored (ready)", int'(req_ready), 0);
        end
      end
      for (int c = 0; c < NC; c++) begin
        if (((vec >> c) & 1) != 0) begin
          ack_valid = 1'b1;
          ack_cid   = c[CID_W-1:0];
          tick();
          ack_valid = 1'b0;
          chk("R9", "no response before last ack settles", int'(rsp_valid), 0);
          chk("R7", "req_ready held low", int'(req_ready), 0);
        end
      end
      tick();
      chk("R9", "replay rsp_valid", int'(rsp_valid), 1);
      chk("R9", "replay rsp_hit", int'(rsp_hit), 0);
      chk("R9", "replay rsp_sharers", int'(rsp_sharers), 0);
      chk("R9", "replay rsp_addr", int'(rsp_addr), addr);
      chk("R9", "replay rsp_cid", int'(rsp_cid), src);
      chk("R7", "req_ready back with response", int'(req_ready), 1);
      m_vld[set][vic] = 1;
      m_tag[set][vic] = tag;
      m_shr[set][vic] = 1 << src;
      m_rr[set]       = (vic + 1) % WAYS;
    end
  endtask

  task automatic idle_ack(input int cid);
    ack_valid = 1'b1;
    ack_cid   = cid[CID_W-1:0];
    tick();
    ack_valid = 1'b0;
    chk("R8", "idle ack: no invalidation", int'(inv_valid), 0);
    chk("R8", "idle ack: no response", int'(rsp_valid), 0);
    chk("R8", "idle ack: still ready", int'(req_ready), 1);
  endtask

  bit run_over = 1'b0;

  initial begin
    #(8 * 100000);
    if (!run_over) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = 0; m_shr[s][w] = 0;
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_src = '0;
    ack_valid = 1'b0; ack_cid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "req_ready in reset", int'(req_ready), 1);
    chk("R1", "inv_valid in reset", int'(inv_valid), 0);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // Set 0: sharer vector growth, exclusive collapse, release
    send_req(0, 1, 0, 0, "R2", 1'b0);
    send_req(0, 1, 0, 2, "R3", 1'b0);
    send_req(0, 1, 0, 1, "R3", 1'b0);
    send_req(1, 1, 0, 3, "R4", 1'b0);
    send_req(0, 1, 0, 0, "R3", 1'b0);
    send_req(2, 1, 0, 0, "R5", 1'b0);
    send_req(2, 1, 0, 3, "R5", 1'b0);
    send_req(0, 1, 0, 1, "R5", 1'b0);   // freed entry misses again
    send_req(2, 9, 0, 2, "R5", 1'b0);   // release of absent block
    send_req(1, 5, 0, 2, "R2", 1'b0);   // exclusive miss with free way

    // Set 1: fill, then three recalls rotating the victim pointer
    send_req(0, 2, 1, 0, "R2", 1'b0);
    send_req(0, 2, 1, 1, "R3", 1'b0);
    send_req(0, 3, 1, 2, "R2", 1'b0);
    idle_ack(0);
    send_req(0, 4, 1, 3, "R6", 1'b1);   // victim way 0, two sharers
    send_req(0, 2, 1, 0, "R6", 1'b1);   // victim way 1
    send_req(0, 3, 1, 1, "R6", 1'b0);   // pointer wrapped to way 0
    send_req(0, 4, 1, 2, "R9", 1'b0);   // recalled block misses, recall again

    // Set 2: exclusive request triggers a recall; release frees a way
    send_req(0, 5, 2, 0, "R2", 1'b0);
    send_req(0, 6, 2, 1, "R2", 1'b0);
    send_req(0, 6, 2, 2, "R3", 1'b0);
    send_req(1, 7, 2, 3, "R6", 1'b1);
    send_req(2, 6, 2, 1, "R5", 1'b0);
    send_req(2, 6, 2, 2, "R5", 1'b0);
    send_req(0, 8, 2, 0, "R5", 1'b0);   // reuses freed way, no recall

    run_over = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule